// File: doc/BRIEF.md
# Data Hazard and Operand Forwarding Unit

This unit resolves read-after-write hazards for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. It contains the 32-entry register file. The two decode-stage source register numbers read the file through a same-cycle writeback bypass, so a value written in writeback is visible to decode in that same cycle.

The unit keeps its own copy of the source numbers of the instruction now in execute. It compares them with the destinations held in the memory and writeback pipeline registers and emits one select code per operand. The operand multiplexers outside the unit use these codes. The youngest producer always wins.

A load in execute whose destination is needed by the instruction in decode raises a hold. The hold freezes fetch and decode and turns the next execute slot into a bubble. A two-state controller allows only one hold cycle per hazard. In state `S_FLOW` the controller passes a detected load-use hazard to the outputs and moves to `S_HOLD`. If no hazard is detected it stays in `S_FLOW`. In `S_HOLD` the hold is masked, and the controller always returns to `S_FLOW` on the next clock.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Register 0 always reads as zero. A write to it changes nothing, and a producer whose destination is 0 never causes a select code other than 00, a bypass or a hold.
- R2: When writeback writes a nonzero register that decode reads in the same cycle, the decode read data equals the writeback data. Values that have been written stay readable in later cycles.
- R3: Select codes are 00 for the decode-read value, 01 for the writeback result and 10 for the memory-stage result. If the memory stage and the writeback stage both hold a pending write to an operand's register, the code is 10.
- R4: If only the writeback stage holds a pending write to an operand's register, that operand's code is 01.
- R5: If execute holds a load with write enable set and a nonzero destination that equals either decode source, `stall_fd` and `bubble_ex` are high in that cycle. The controller moves from `S_FLOW` to `S_HOLD`, and both signals are low in the following cycle whatever the inputs are. A non-load producer in execute never causes a hold.
- R6: A producer with its write enable low never causes a forward, a bypass or a hold.
- R7: In the cycle after a hold, execute contains a bubble and both select codes are 00.
- R8: For the sequence load r6, load r5, then a consumer of r6 and r5, decode holds for exactly one cycle. The consumer's r6 operand comes from the register file with code 00, and its r5 operand is forwarded from writeback with code 01.
- R9: After reset the hold is low, both codes are 00 and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs1 | input | 5 | First decode source register |
| id_rs2 | input | 5 | Second decode source register |
| ex_rd | input | 5 | Destination in the execute pipeline register |
| ex_we | input | 1 | Write enable in execute |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination in the memory pipeline register |
| mem_we | input | 1 | Write enable in memory |
| wb_rd | input | 5 | Destination in the writeback pipeline register |
| wb_we | input | 1 | Write enable in writeback |
| wb_data | input | 32 | Writeback result |
| stall_fd | output | 1 | Hold fetch and decode |
| bubble_ex | output | 1 | Load a bubble into execute |
| fwd_a | output | 2 | Select code, first execute operand |
| fwd_b | output | 2 | Select code, second execute operand |
| id_data_a | output | 32 | Decode read data, first source |
| id_data_b | output | 32 | Decode read data, second source |

## Verification
The properties assume that the surrounding pipeline obeys the hold. They assume it inserts the requested bubble and never presents a load in the memory stage to a dependent instruction in execute, because that case cannot be forwarded. The forwarding properties compare the memory and writeback destinations with the decode sources of the previous cycle, and they only apply when that cycle was not a hold. The stimulus keeps to these assumptions except in one deliberate cycle. In that cycle the load is left in execute during `S_HOLD`, to show that the controller still releases after one cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int NREG = 32;
    localparam int XLEN = 32;
    localparam int AW   = $clog2(NREG);

    // Operand source select for the execute stage
    typedef enum logic [1:0] {
        SEL_DEC = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } opsel_e;

    // Hold controller states
    typedef enum logic {
        S_FLOW = 1'b0,
        S_HOLD = 1'b1
    } gate_e;

endpackage

// File: rtl/hz_regfile.sv
module hz_regfile
    import hz_pkg::*;
#(
    parameter int NR   = NREG,
    parameter int W    = XLEN,
    parameter int NRD  = 2,
    localparam int A   = $clog2(NR)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [A-1:0]          wr_addr,
    input  logic [W-1:0]          wr_data,
    input  logic [NRD-1:0][A-1:0] rd_addr,
    output logic [NRD-1:0][W-1:0] rd_data
);

    logic [W-1:0] cells [NR];
    logic         wr_live;

    // Writes to register zero are dropped
    assign wr_live = wr_en && (wr_addr != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_live) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // One read port per source; same-cycle write is bypassed
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == '0) begin
                rd_data[p] = '0;
            end else if (wr_live && (wr_addr == rd_addr[p])) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = cells[rd_addr[p]];
            end
        end
    end

endmodule

// File: rtl/hz_opsel.sv
module hz_opsel
    import hz_pkg::*;
#(
    parameter int A = AW
) (
    input  logic [A-1:0] src,
    input  logic [A-1:0] mem_rd,
    input  logic         mem_we,
    input  logic [A-1:0] wb_rd,
    input  logic         wb_we,
    output opsel_e       sel
);

    logic hit_mem;
    logic hit_wb;

    assign hit_mem = mem_we && (mem_rd != '0) && (mem_rd == src);
    assign hit_wb  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);

    // Youngest producer first
    always_comb begin
        if (hit_mem) begin
            sel = SEL_MEM;
        end else if (hit_wb) begin
            sel = SEL_WB;
        end else begin
            sel = SEL_DEC;
        end
    end

endmodule

// File: rtl/hz_stall_fsm.sv
module hz_stall_fsm
    import hz_pkg::*;
#(
    parameter int A    = AW,
    parameter int NSRC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0][A-1:0] src,
    input  logic [A-1:0]           ex_rd,
    input  logic                   ex_we,
    input  logic                   ex_load,
    output logic                   hold
);

    gate_e           state_q;
    gate_e           state_d;
    logic [NSRC-1:0] dep;
    logic            hazard;
    logic            ld_live;

    assign ld_live = ex_load && ex_we && (ex_rd != '0);

    for (genvar s = 0; s < NSRC; s++) begin : g_dep
        assign dep[s] = ld_live && (src[s] == ex_rd);
    end

    assign hazard = |dep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FLOW: state_d = hazard ? S_HOLD : S_FLOW;
            S_HOLD: state_d = S_FLOW;
        endcase
    end

    always_comb begin
        hold = 1'b0;
        unique case (state_q)
            S_FLOW: hold = hazard;
            S_HOLD: hold = 1'b0;
        endcase
    end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hz_pkg::*;
#(
    parameter int NR   = NREG,
    parameter int W    = XLEN,
    localparam int A   = $clog2(NR),
    localparam int NOP = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [A-1:0] id_rs1,
    input  logic [A-1:0] id_rs2,
    input  logic [A-1:0] ex_rd,
    input  logic         ex_we,
    input  logic         ex_is_load,
    input  logic [A-1:0] mem_rd,
    input  logic         mem_we,
    input  logic [A-1:0] wb_rd,
    input  logic         wb_we,
    input  logic [W-1:0] wb_data,
    output logic         stall_fd,
    output logic         bubble_ex,
    output logic [1:0]   fwd_a,
    output logic [1:0]   fwd_b,
    output logic [W-1:0] id_data_a,
    output logic [W-1:0] id_data_b
);

    logic [NOP-1:0][A-1:0] id_src;
    logic [NOP-1:0][A-1:0] ex_src_q;
    logic [NOP-1:0][W-1:0] rd_val;
    opsel_e [NOP-1:0]      sel;
    logic                  hold;

    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;

    hz_regfile #(
        .NR  (NR),
        .W   (W),
        .NRD (NOP)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_we),
        .wr_addr (wb_rd),
        .wr_data (wb_data),
        .rd_addr (id_src),
        .rd_data (rd_val)
    );

    hz_stall_fsm #(
        .A    (A),
        .NSRC (NOP)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (id_src),
        .ex_rd   (ex_rd),
        .ex_we   (ex_we),
        .ex_load (ex_is_load),
        .hold    (hold)
    );

    // Source numbers follow the instruction into execute; a hold sends a bubble
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_src_q <= '0;
        end else if (hold) begin
            ex_src_q <= '0;
        end else begin
            ex_src_q <= id_src;
        end
    end

    for (genvar k = 0; k < NOP; k++) begin : g_op
        hz_opsel #(
            .A (A)
        ) u_sel (
            .src    (ex_src_q[k]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel[k])
        );
    end

    assign stall_fd  = hold;
    assign bubble_ex = hold;
    assign fwd_a     = sel[0];
    assign fwd_b     = sel[1];
    assign id_data_a = rd_val[0];
    assign id_data_b = rd_val[1];

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
    parameter int A = 5,
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [A-1:0] id_rs1,
    input logic [A-1:0] id_rs2,
    input logic [A-1:0] ex_rd,
    input logic         ex_we,
    input logic         ex_is_load,
    input logic [A-1:0] mem_rd,
    input logic         mem_we,
    input logic [A-1:0] wb_rd,
    input logic         wb_we,
    input logic [W-1:0] wb_data,
    input logic         stall_fd,
    input logic         bubble_ex,
    input logic [1:0]   fwd_a,
    input logic [1:0]   fwd_b,
    input logic [W-1:0] id_data_a,
    input logic [W-1:0] id_data_b
);

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0) |-> (id_data_a == '0)); // R1

    AST_WB_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_rd != '0 && wb_rd == id_rs2) |-> (id_data_b == wb_data)); // R2

    AST_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && mem_we && mem_rd != '0 && mem_rd == $past(id_rs1) && !$past(stall_fd))
        |-> (fwd_a == 2'b10)); // R3

    AST_WB_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && wb_we && wb_rd != '0 && wb_rd == $past(id_rs2) && !$past(stall_fd)
         && !(mem_we && mem_rd == $past(id_rs2)))
        |-> (fwd_b == 2'b01)); // R4

    AST_LOAD_USE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(stall_fd) && ex_is_load && ex_we && ex_rd != '0 && ex_rd == id_rs1)
        |-> (stall_fd && bubble_ex)); // R5

    AST_HOLD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fd |=> !stall_fd); // R5

    AST_IDLE_PRODUCERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !wb_we) |-> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R6

    AST_BUBBLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(stall_fd)) |-> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R7

endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.A(A), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_rs1     (id_rs1),
    .id_rs2     (id_rs2),
    .ex_rd      (ex_rd),
    .ex_we      (ex_we),
    .ex_is_load (ex_is_load),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we),
    .wb_rd      (wb_rd),
    .wb_we      (wb_we),
    .wb_data    (wb_data),
    .stall_fd   (stall_fd),
    .bubble_ex  (bubble_ex),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b),
    .id_data_a  (id_data_a),
    .id_data_b  (id_data_b)
);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        string       tag;
        bit          cs;
        bit          s;
        bit          cf;
        logic [1:0]  fa;
        logic [1:0]  fb;
        bit          ca;
        logic [31:0] da;
        bit          cb;
        logic [31:0] db;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic        ex_we = 1'b0, ex_is_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [31:0] wb_data = '0;
    logic        stall_fd, bubble_ex;
    logic [1:0]  fwd_a, fwd_b;
    logic [31:0] id_data_a, id_data_b;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hazard_fwd_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .mem_rd     (mem_rd),
        .mem_we     (mem_we),
        .wb_rd      (wb_rd),
        .wb_we      (wb_we),
        .wb_data    (wb_data),
        .stall_fd   (stall_fd),
        .bubble_ex  (bubble_ex),
        .fwd_a      (fwd_a),
        .fwd_b      (fwd_b),
        .id_data_a  (id_data_a),
        .id_data_b  (id_data_b)
    );

    function automatic exp_t mk(string t, bit cs, bit s, bit cf, logic [1:0] fa,
                                logic [1:0] fb, bit ca, logic [31:0] da, bit cb,
                                logic [31:0] db);
        exp_t e;
        e.tag = t; e.cs = cs; e.s = s; e.cf = cf; e.fa = fa; e.fb = fb;
        e.ca = ca; e.da = da; e.cb = cb; e.db = db;
        return e;
    endfunction

    function automatic exp_t none();
        return mk("", 0, 0, 0, 2'b00, 2'b00, 0, '0, 0, '0);
    endfunction

    // Driver: one pipeline cycle of inputs plus its expected outputs
    task automatic cyc(input logic [4:0] r1, input logic [4:0] r2,
                       input logic [4:0] erd, input bit ewe, input bit eld,
                       input logic [4:0] mrd, input bit mwe,
                       input logic [4:0] wrd, input bit wwe, input logic [31:0] wd,
                       input exp_t e);
        @(posedge clk);
        #1;
        id_rs1 = r1; id_rs2 = r2;
        ex_rd = erd; ex_we = ewe; ex_is_load = eld;
        mem_rd = mrd; mem_we = mwe;
        wb_rd = wrd; wb_we = wwe; wb_data = wd;
        q.push_back(e);
    endtask

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.cs) begin
                cmp(e.tag, "stall_fd", {31'd0, stall_fd}, {31'd0, e.s});
                cmp(e.tag, "bubble_ex", {31'd0, bubble_ex}, {31'd0, e.s});
            end
            if (e.cf) begin
                cmp(e.tag, "fwd_a", {30'd0, fwd_a}, {30'd0, e.fa});
                cmp(e.tag, "fwd_b", {30'd0, fwd_b}, {30'd0, e.fb});
            end
            if (e.ca) cmp(e.tag, "id_data_a", id_data_a, e.da);
            if (e.cb) cmp(e.tag, "id_data_b", id_data_b, e.db);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, mk("R9", 1, 0, 1, 2'b00, 2'b00, 1, 0, 1, 0));
        // R2 same-cycle bypass, r7 still zero
        cyc(6, 7, 0, 0, 0, 0, 0, 6, 1, 32'h66, mk("R2", 0, 0, 0, 0, 0, 1, 32'h66, 1, 0));
        // R2 value kept in the array
        cyc(6, 0, 0, 0, 0, 0, 0, 5, 1, 32'h55, mk("R2", 0, 0, 0, 0, 0, 1, 32'h66, 0, 0));
        // R1 write to register 0 while reading it
        cyc(0, 5, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD, mk("R1", 0, 0, 0, 0, 0, 1, 0, 1, 32'h55));
        // R1 register 0 still zero; R6 disabled write not bypassed
        cyc(0, 7, 0, 0, 0, 0, 0, 7, 0, 32'h77, mk("R1/R6", 0, 0, 0, 0, 0, 1, 0, 1, 0));
        // R6 disabled write not stored
        cyc(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, mk("R6", 0, 0, 0, 0, 0, 1, 0, 0, 0));

        // R3/R4 back-to-back ALU producers
        cyc(3, 4, 0, 0, 0, 0, 0, 0, 0, 0, none());
        cyc(0, 0, 0, 0, 0, 3, 1, 4, 1, 32'h44, mk("R3/R4", 1, 0, 1, 2'b10, 2'b01, 0, 0, 0, 0));
        // R3 both stages match both operands: memory stage wins
        cyc(8, 8, 0, 0, 0, 0, 0, 0, 0, 0, none());
        cyc(0, 0, 0, 0, 0, 8, 1, 8, 1, 32'h88, mk("R3", 0, 0, 1, 2'b10, 2'b10, 0, 0, 0, 0));
        // R6 matching destinations with write enable low
        cyc(9, 9, 0, 0, 0, 0, 0, 0, 0, 0, none());
        cyc(0, 0, 0, 0, 0, 9, 0, 9, 0, 32'h99, mk("R6", 0, 0, 1, 2'b00, 2'b00, 0, 0, 0, 0));
        // R1 producers targeting register 0
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, none());
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 32'hBAD, mk("R1", 0, 0, 1, 2'b00, 2'b00, 0, 0, 0, 0));

        // R1 load to register 0 is no hazard
        cyc(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, mk("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0));
        // R6 load with write enable low
        cyc(5, 5, 5, 0, 1, 0, 0, 0, 0, 0, mk("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0));
        // R5 non-load producer never holds
        cyc(5, 0, 5, 1, 0, 0, 0, 0, 0, 0, mk("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0));
        // R5 load-use on second source
        cyc(0, 11, 11, 1, 1, 0, 0, 0, 0, 0, mk("R5", 1, 1, 0, 0, 0, 0, 0, 0, 0));
        // R5 released after one cycle even with the hazard still present; R7 bubble
        cyc(0, 11, 11, 1, 1, 0, 0, 0, 0, 0, mk("R5/R7", 1, 0, 1, 2'b00, 2'b00, 0, 0, 0, 0));
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, none());

        // R8 load r6, load r5, consumer of r6 and r5
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, none());
        cyc(2, 0, 6, 1, 1, 0, 0, 0, 0, 0, mk("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0));
        cyc(6, 5, 5, 1, 1, 6, 1, 0, 0, 0, mk("R8", 1, 1, 0, 0, 0, 0, 0, 0, 0));
        cyc(6, 5, 0, 0, 0, 5, 1, 6, 1, 32'h600,
            mk("R8/R7", 1, 0, 1, 2'b00, 2'b00, 1, 32'h600, 1, 32'h55));
        cyc(0, 0, 0, 0, 0, 0, 0, 5, 1, 32'h500, mk("R8", 1, 0, 1, 2'b00, 2'b01, 0, 0, 0, 0));
        // R2 both loaded values persist
        cyc(6, 5, 0, 0, 0, 0, 0, 0, 0, 0, mk("R2", 0, 0, 0, 0, 0, 1, 32'h600, 1, 32'h500));

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule